// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block paces a multiplexed external memory bus from a twelve-period machine cycle counted on the oscillator clock. Once per machine cycle it chooses what the bus does next: a data read, a data write, a code fetch of two consecutive bytes, or an idle cycle. It then drives the address-latch strobe, the code-read strobe, the data read and write strobes, the shared low address/data byte and the high address byte. Data and code bytes returned on the low byte lane are captured and presented with a one-cycle valid pulse.

Requesters present their request levels together with the program counter, the data pointer, the 8-bit indirect pointer, the high-port register value and the write byte. They hold these while `slot_open` is high; all of them are sampled on the clock edge that ends that period, and the chosen cycle starts at phase 0. A data cycle drops the second address-latch pulse and both code-read pulses of the machine cycle. A latch-suppress control silences the address-latch strobe during idle cycles, but only while code runs from internal memory.

Top module: `ext_bus_sequencer`

## Requirements
- R1: During idle and code-fetch machine cycles `ale` is high in phases 0, 1, 6 and 7 and low in every other phase. Each pulse is 2 periods wide and a pulse starts every 6 periods.
- R2: During a code-fetch cycle `psen_n` is low in phases 3–5 and 9–11, which is 1 period after each `ale` fall, for 3 periods. `p0_out` carries the low byte of the fetch address with `p0_oe` high in phases 0–2 and 6–8. The first fetch address is `pc` and the second is `pc`+1, modulo 2^16. `p2_out` carries the high byte of the first address in phases 0–5 and of the second address in phases 6–11.
- R3: During a data cycle `ale` pulses only in phases 0–1, and `psen_n` stays high for the whole machine cycle.
- R4: `rd_n` (data read) or `wr_n` (data write) is low in phases 5–10, which is 3 periods after `ale` falls, for 6 periods. The two strobes are never low together, and neither is ever low together with `psen_n`.
- R5: A data cycle with `wide_addr`=1 drives `p2_out` with `dptr[15:8]` and the address phases 0–2 of `p0_out` with `dptr[7:0]`. A data cycle with `wide_addr`=0 drives `p2_out` with `p2_reg` and the address phases with `ri_ptr`.
- R6: During a write cycle `p0_oe` stays high for all twelve phases, and `p0_out` carries `wdata` in phases 3–11, which extends one period past the rise of `wr_n`.
- R7: `p0_in` is captured into `rdata` at the clock edge that ends phase 10 of a read cycle, and at the edges that end phases 5 and 11 of a fetch cycle. `rdata_vld` is high for the single period after each capture and low otherwise.
- R8: With `ale_off`=1 and `ext_exec`=0, an idle machine cycle keeps `ale` low throughout. Data and fetch cycles still pulse `ale`. With `ext_exec`=1, `ale_off` has no effect.
- R9: `slot_open` is high only in phase 11. Requests are sampled at the edge that ends phase 11, with priority read over write over fetch over idle.
- R10: While `rst_n` is low, `ale`=0, `psen_n`=`rd_n`=`wr_n`=1, `p0_oe`=0, `rdata_vld`=0 and `slot_open`=0. The first machine cycle after reset drives no strobe.
- R11: An idle cycle leaves `p0_oe` low and drives `p2_out` with `p2_reg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one phase per period |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_req | input | 1 | Request a two-byte code fetch cycle |
| rd_req | input | 1 | Request a data read cycle |
| wr_req | input | 1 | Request a data write cycle |
| wide_addr | input | 1 | Data address from the data pointer (1) or the indirect pointer (0) |
| ext_exec | input | 1 | Code currently runs from external memory |
| ale_off | input | 1 | Suppress the address-latch strobe in idle cycles |
| pc | input | 16 | Program counter for fetch addresses |
| dptr | input | 16 | 16-bit data pointer |
| ri_ptr | input | 8 | 8-bit indirect data pointer |
| p2_reg | input | 8 | High-port register contents |
| wdata | input | 8 | Byte to write |
| p0_in | input | 8 | Low byte lane as seen at the pins |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Code-read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Low address/data byte driven out |
| p0_oe | output | 1 | Output enable for the low byte lane |
| p2_out | output | 8 | High address byte |
| rdata | output | 8 | Last captured byte |
| rdata_vld | output | 1 | One-period pulse after each capture |
| slot_open | output | 1 | High in the period whose closing edge samples requests |

## Verification
If the phase counter slips, the next `ale` pulse is spaced wrongly within the very next machine cycle. That is at most twelve periods later. If the cycle kind is latched wrongly, the strobe pattern or the port 2 byte is wrong within three periods of the following phase 0. A capture taken one edge early or late shows as a byte from the wrong phase in `rdata`, because the bench puts a phase-tagged value on `p0_in` every period. A late release of the low byte lane shows as `p0_oe` high while a read strobe is low.

// File: rtl/bus_seq_pkg.sv
// Package: shared widths, cycle kinds and phase windows of the bus sequencer.
// Assumes a machine cycle of PHASES oscillator periods split into two halves.
package bus_seq_pkg;
    parameter int ADDR_W = 16;
    parameter int BYTE_W = 8;
    parameter int PHASES = 12;
    localparam int PH_W = $clog2(PHASES);

    typedef logic [PH_W-1:0] phase_t;

    // Phase windows; the strobe relations of the bus depend on these positions.
    localparam phase_t PH_LAST   = phase_t'(PHASES - 1);
    localparam phase_t SLOT_B    = phase_t'(PHASES / 2);
    localparam phase_t ALE_LEN   = phase_t'(2);
    localparam phase_t ADDR_LEN  = phase_t'(3);
    localparam phase_t PSEN_OFS  = phase_t'(3);
    localparam phase_t PSEN_LEN  = phase_t'(3);
    localparam phase_t PSEN_OFSB = phase_t'(PHASES / 2 + 3);
    localparam phase_t XS_OFS    = phase_t'(5);
    localparam phase_t XS_LEN    = phase_t'(6);
    localparam phase_t WD_OFS    = phase_t'(3);
    localparam phase_t WD_LEN    = phase_t'(PHASES - 3);
    localparam phase_t CAP_A     = phase_t'(5);
    localparam phase_t CAP_B     = phase_t'(PHASES / 2 + 5);
    localparam phase_t CAP_D     = phase_t'(10);

    typedef enum logic [2:0] {
        CK_QUIET = 3'd0,
        CK_IDLE  = 3'd1,
        CK_FETCH = 3'd2,
        CK_DRD   = 3'd3,
        CK_DWR   = 3'd4
    } cyc_kind_e;

    typedef struct packed {
        cyc_kind_e         kind;
        logic [ADDR_W-1:0] addr_a;
        logic [ADDR_W-1:0] addr_b;
        logic [BYTE_W-1:0] wbyte;
    } bus_cyc_t;

    localparam bus_cyc_t CYC_RESET = '{kind: CK_QUIET, addr_a: '0, addr_b: '0, wbyte: '0};

    // True when phase p lies in [s, s+l).
    function automatic logic in_win(input phase_t p, input phase_t s, input phase_t l);
        return ({1'b0, p} >= {1'b0, s}) && ({1'b0, p} < ({1'b0, s} + {1'b0, l}));
    endfunction
endpackage

// File: rtl/bus_phase_ctr.sv
// Phase counter: counts oscillator periods 0..PHASES-1 of a machine cycle.
// Provides the present phase, the phase of the next period and the wrap flag.
module bus_phase_ctr
    import bus_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_t phase_q,
    output phase_t phase_nxt,
    output logic   wrap
);
    // Wrap flag and next phase value.
    always_comb begin
        wrap      = (phase_q == PH_LAST);
        phase_nxt = wrap ? '0 : phase_q + phase_t'(1);
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_nxt;
    end
endmodule

// File: rtl/bus_cycle_sel.sv
// Cycle selector: at each machine-cycle wrap, picks the next bus cycle from the
// requests (read > write > fetch > idle) and freezes its addresses and write byte.
// Assumes requesters hold their inputs through the sampling period.
module bus_cycle_sel
    import bus_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrap,
    input  logic              fetch_req,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic              wide_addr,
    input  logic              ext_exec,
    input  logic              ale_off,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] dptr,
    input  logic [BYTE_W-1:0] ri_ptr,
    input  logic [BYTE_W-1:0] p2_reg,
    input  logic [BYTE_W-1:0] wdata,
    output bus_cyc_t          cyc_cur,
    output bus_cyc_t          cyc_nxt
);
    bus_cyc_t pick;
    logic [ADDR_W-1:0] data_addr;

    // Choose the kind and addresses of the cycle that would start next.
    always_comb begin
        data_addr   = wide_addr ? dptr : {p2_reg, ri_ptr};
        pick.wbyte  = wdata;
        pick.addr_b = pc + ADDR_W'(1);
        pick.addr_a = {p2_reg, {BYTE_W{1'b1}}};
        if (rd_req) begin
            pick.kind   = CK_DRD;
            pick.addr_a = data_addr;
        end else if (wr_req) begin
            pick.kind   = CK_DWR;
            pick.addr_a = data_addr;
        end else if (fetch_req) begin
            pick.kind   = CK_FETCH;
            pick.addr_a = pc;
        end else if (ale_off && !ext_exec) begin
            pick.kind   = CK_QUIET;
        end else begin
            pick.kind   = CK_IDLE;
        end
        cyc_nxt = wrap ? pick : cyc_cur;
    end

    // Current-cycle register.
    always_ff @(posedge clk) begin
        if (!rst_n) cyc_cur <= CYC_RESET;
        else        cyc_cur <= cyc_nxt;
    end
endmodule

// File: rtl/bus_pin_drv.sv
// Pin driver: decodes the strobes and byte lanes for the coming period from the
// next phase and next cycle, and registers them so the pins change only at edges.
// Assumes cyc_nxt/phase_nxt are the values that take effect at the same edge.
module bus_pin_drv
    import bus_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            phase_nxt,
    input  bus_cyc_t          cyc_nxt,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [BYTE_W-1:0] p0_out,
    output logic              p0_oe,
    output logic [BYTE_W-1:0] p2_out,
    output logic              slot_open
);
    logic              ale_d, psen_d, rd_d, wr_d, oe_d, slot_b, pair_ale;
    logic [BYTE_W-1:0] p0_d, p2_d;

    // Decode of every pin for the coming period.
    always_comb begin
        slot_b   = (phase_nxt >= SLOT_B);
        pair_ale = in_win(phase_nxt, '0, ALE_LEN) || in_win(phase_nxt, SLOT_B, ALE_LEN);
        ale_d    = 1'b0;
        psen_d   = 1'b1;
        rd_d     = 1'b1;
        wr_d     = 1'b1;
        oe_d     = 1'b0;
        p0_d     = {BYTE_W{1'b1}};
        p2_d     = cyc_nxt.addr_a[ADDR_W-1 -: BYTE_W];
        case (cyc_nxt.kind)
            CK_IDLE: ale_d = pair_ale;
            CK_FETCH: begin
                ale_d  = pair_ale;
                psen_d = !(in_win(phase_nxt, PSEN_OFS, PSEN_LEN) ||
                           in_win(phase_nxt, PSEN_OFSB, PSEN_LEN));
                oe_d   = in_win(phase_nxt, '0, ADDR_LEN) || in_win(phase_nxt, SLOT_B, ADDR_LEN);
                p0_d   = slot_b ? cyc_nxt.addr_b[BYTE_W-1:0] : cyc_nxt.addr_a[BYTE_W-1:0];
                p2_d   = slot_b ? cyc_nxt.addr_b[ADDR_W-1 -: BYTE_W]
                                : cyc_nxt.addr_a[ADDR_W-1 -: BYTE_W];
            end
            CK_DRD: begin
                ale_d = in_win(phase_nxt, '0, ALE_LEN);
                rd_d  = !in_win(phase_nxt, XS_OFS, XS_LEN);
                oe_d  = in_win(phase_nxt, '0, ADDR_LEN);
                p0_d  = cyc_nxt.addr_a[BYTE_W-1:0];
            end
            CK_DWR: begin
                ale_d = in_win(phase_nxt, '0, ALE_LEN);
                wr_d  = !in_win(phase_nxt, XS_OFS, XS_LEN);
                oe_d  = in_win(phase_nxt, '0, ADDR_LEN) || in_win(phase_nxt, WD_OFS, WD_LEN);
                p0_d  = in_win(phase_nxt, '0, ADDR_LEN) ? cyc_nxt.addr_a[BYTE_W-1:0]
                                                        : cyc_nxt.wbyte;
            end
            default: ;
        endcase
    end

    // Output registers: glitch-free pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale       <= 1'b0;
            psen_n    <= 1'b1;
            rd_n      <= 1'b1;
            wr_n      <= 1'b1;
            p0_out    <= '0;
            p0_oe     <= 1'b0;
            p2_out    <= '0;
            slot_open <= 1'b0;
        end else begin
            ale       <= ale_d;
            psen_n    <= psen_d;
            rd_n      <= rd_d;
            wr_n      <= wr_d;
            p0_out    <= p0_d;
            p0_oe     <= oe_d;
            p2_out    <= p2_d;
            slot_open <= (phase_nxt == PH_LAST);
        end
    end

    assert_ale_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |=> ale ##1 !ale);
    assert_psen_lag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(psen_n) |-> (!$past(ale) && $past(ale, 2)));
    assert_psen_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(psen_n) |-> (!$past(psen_n, 3) && $past(psen_n, 4)));
    assert_data_one_ale_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> (!ale && psen_n));
    assert_xs_lag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n) || $fell(wr_n)) |-> ($past(ale, 4) && !$past(ale, 3)));
    assert_rd_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n) |-> (!$past(rd_n, 6) && $past(rd_n, 7)));
    assert_wr_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> (!$past(wr_n, 6) && $past(wr_n, 7)));
    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!psen_n, !rd_n, !wr_n}) <= 1);
    assert_lane_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !psen_n) |-> !p0_oe);
    assert_wdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> p0_oe);
endmodule

// File: rtl/bus_rd_capture.sv
// Read capture: samples the low byte lane at the last strobe-low period of a
// data read and of each code byte, and flags the captured byte for one period.
// Assumes phase_q and the current cycle kind describe the period being closed.
module bus_rd_capture
    import bus_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            phase_q,
    input  cyc_kind_e         kind,
    input  logic [BYTE_W-1:0] p0_in,
    output logic [BYTE_W-1:0] rdata,
    output logic              rdata_vld
);
    logic take;

    // Capture instant for the running cycle.
    always_comb begin
        take = ((kind == CK_FETCH) && ((phase_q == CAP_A) || (phase_q == CAP_B))) ||
               ((kind == CK_DRD) && (phase_q == CAP_D));
    end

    // Captured byte and its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata     <= '0;
            rdata_vld <= 1'b0;
        end else begin
            rdata_vld <= take;
            if (take) rdata <= p0_in;
        end
    end
endmodule

// File: rtl/ext_bus_sequencer.sv
// Top: multiplexed external bus cycle sequencer. Counts the machine cycle,
// selects each cycle's kind, drives the bus pins and captures returned bytes.
// Assumes clk is the oscillator; one phase per clock period.
module ext_bus_sequencer
    import bus_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic              wide_addr,
    input  logic              ext_exec,
    input  logic              ale_off,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] dptr,
    input  logic [BYTE_W-1:0] ri_ptr,
    input  logic [BYTE_W-1:0] p2_reg,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] p0_in,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [BYTE_W-1:0] p0_out,
    output logic              p0_oe,
    output logic [BYTE_W-1:0] p2_out,
    output logic [BYTE_W-1:0] rdata,
    output logic              rdata_vld,
    output logic              slot_open
);
    phase_t   phase_q, phase_nxt;
    logic     wrap;
    bus_cyc_t cyc_cur, cyc_nxt;

    bus_phase_ctr u_phase (
        .clk(clk), .rst_n(rst_n), .phase_q(phase_q), .phase_nxt(phase_nxt), .wrap(wrap)
    );

    bus_cycle_sel u_sel (
        .clk(clk), .rst_n(rst_n), .wrap(wrap),
        .fetch_req(fetch_req), .rd_req(rd_req), .wr_req(wr_req),
        .wide_addr(wide_addr), .ext_exec(ext_exec), .ale_off(ale_off),
        .pc(pc), .dptr(dptr), .ri_ptr(ri_ptr), .p2_reg(p2_reg), .wdata(wdata),
        .cyc_cur(cyc_cur), .cyc_nxt(cyc_nxt)
    );

    bus_pin_drv u_pins (
        .clk(clk), .rst_n(rst_n), .phase_nxt(phase_nxt), .cyc_nxt(cyc_nxt),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out), .slot_open(slot_open)
    );

    bus_rd_capture u_cap (
        .clk(clk), .rst_n(rst_n), .phase_q(phase_q), .kind(cyc_cur.kind),
        .p0_in(p0_in), .rdata(rdata), .rdata_vld(rdata_vld)
    );

    assert_vld_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_vld |-> ($past(!rd_n) || $past(!psen_n)));
    assert_open_then_ale_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slot_open) |-> !$past(ale));
endmodule

// File: tb/tb_ext_bus_sequencer.sv
module tb_ext_bus_sequencer;
    localparam int K_QUIET = 0, K_IDLE = 1, K_FETCH = 2, K_RD = 3, K_WR = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fetch_req = 0, rd_req = 0, wr_req = 0, wide_addr = 0, ext_exec = 0, ale_off = 0;
    logic [15:0] pc = '0, dptr = '0;
    logic [7:0]  ri_ptr = '0, p2_reg = '0, wdata = '0, p0_in = '0;
    logic ale, psen_n, rd_n, wr_n, p0_oe, rdata_vld, slot_open;
    logic [7:0] p0_out, p2_out, rdata;

    int checks = 0, errors = 0;
    int nxt_kind, cur_kind, prev_kind;
    logic [15:0] nxt_a, nxt_b, cur_a, cur_b;
    logic [7:0]  nxt_wd, cur_wd, rv, prev_rv;

    always #2 clk = ~clk;

    ext_bus_sequencer dut (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .rd_req(rd_req), .wr_req(wr_req),
        .wide_addr(wide_addr), .ext_exec(ext_exec), .ale_off(ale_off), .pc(pc), .dptr(dptr),
        .ri_ptr(ri_ptr), .p2_reg(p2_reg), .wdata(wdata), .p0_in(p0_in), .ale(ale),
        .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .p0_out(p0_out), .p0_oe(p0_oe),
        .p2_out(p2_out), .rdata(rdata), .rdata_vld(rdata_vld), .slot_open(slot_open)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s kind=%0d: actual %0h expected %0h", tag, cur_kind, act, exp);
        end
    endtask

    // Expected kind and addresses from the selection rules (R9 priority, R8, R5).
    task automatic set_req(input bit f, input bit r, input bit w, input bit wide,
                           input bit ext, input bit aoff, input logic [15:0] pcv,
                           input logic [15:0] dpv, input logic [7:0] ri, input logic [7:0] p2,
                           input logic [7:0] wd);
        fetch_req = f; rd_req = r; wr_req = w; wide_addr = wide; ext_exec = ext; ale_off = aoff;
        pc = pcv; dptr = dpv; ri_ptr = ri; p2_reg = p2; wdata = wd;
        nxt_kind = r ? K_RD : w ? K_WR : f ? K_FETCH : (aoff && !ext) ? K_QUIET : K_IDLE;
        nxt_b  = pcv + 16'd1;
        nxt_wd = wd;
        if (nxt_kind == K_FETCH) nxt_a = pcv;
        else if (nxt_kind == K_RD || nxt_kind == K_WR) nxt_a = wide ? dpv : {p2, ri};
        else nxt_a = {p2, 8'hFF};
    endtask

    function automatic bit win(input int p, input int s, input int l);
        return p >= s && p < s + l;
    endfunction

    // One machine cycle of checks; requests for the following cycle are set in phase 11.
    task automatic run_cycle(input bit f, input bit r, input bit w, input bit wide,
                             input bit ext, input bit aoff, input logic [15:0] pcv,
                             input logic [15:0] dpv, input logic [7:0] ri,
                             input logic [7:0] p2, input logic [7:0] wd);
        prev_kind = cur_kind; prev_rv = rv;
        cur_kind = nxt_kind; cur_a = nxt_a; cur_b = nxt_b; cur_wd = nxt_wd;
        rv = 8'($urandom);
        for (int p = 0; p < 12; p++) begin
            bit e_ale, e_psen, e_rd, e_wr, e_oe, e_vld;
            logic [7:0] e_p0, e_p2, e_rdata;
            string t_lane;
            @(negedge clk);
            e_ale = (cur_kind == K_IDLE || cur_kind == K_FETCH) ? (win(p,0,2) || win(p,6,2))
                  : (cur_kind == K_RD || cur_kind == K_WR) ? win(p,0,2) : 1'b0;
            e_psen = !(cur_kind == K_FETCH && (win(p,3,3) || win(p,9,3)));
            e_rd = !(cur_kind == K_RD && win(p,5,6));
            e_wr = !(cur_kind == K_WR && win(p,5,6));
            e_oe = (cur_kind == K_FETCH) ? (win(p,0,3) || win(p,6,3))
                 : (cur_kind == K_RD) ? win(p,0,3) : (cur_kind == K_WR);
            e_p0 = (cur_kind == K_FETCH && p >= 6) ? cur_b[7:0]
                 : (cur_kind == K_WR && p >= 3) ? cur_wd : cur_a[7:0];
            e_p2 = (cur_kind == K_FETCH && p >= 6) ? cur_b[15:8] : cur_a[15:8];
            e_vld = (cur_kind == K_FETCH && p == 6) || (cur_kind == K_RD && p == 11) ||
                    (prev_kind == K_FETCH && p == 0);
            e_rdata = (p == 6) ? 8'(rv + 5) : (p == 11) ? 8'(rv + 10) : 8'(prev_rv + 11);
            t_lane = (cur_kind == K_FETCH) ? "R2" : (cur_kind == K_WR && p >= 3) ? "R6"
                   : (cur_kind >= K_RD) ? "R5" : "R11";
            // R1 pulse train, R3 single pulse in data cycles, R8 suppressed idle ALE
            chk((cur_kind >= K_RD) ? "R3 ale" : (cur_kind == K_QUIET) ? "R8 ale" : "R1 ale",
                ale, e_ale);
            chk((cur_kind == K_FETCH) ? "R2 psen_n" : "R3 psen_n", psen_n, e_psen);
            chk("R4 rd_n", rd_n, e_rd);
            chk("R4 wr_n", wr_n, e_wr);
            chk({t_lane, " p0_oe"}, p0_oe, e_oe);
            if (e_oe) chk({t_lane, " p0_out"}, p0_out, e_p0);
            chk({(cur_kind == K_FETCH) ? "R2" : (cur_kind >= K_RD) ? "R5" : "R11", " p2_out"},
                p2_out, e_p2);
            chk("R9 slot_open", slot_open, p == 11);
            chk("R7 rdata_vld", rdata_vld, e_vld);
            if (e_vld) chk("R7 rdata", rdata, e_rdata);
            p0_in = 8'(rv + p);
            if (p == 11) set_req(f, r, w, wide, ext, aoff, pcv, dpv, ri, p2, wd);
        end
    endtask

    task automatic run_random();
        int sel = $urandom % 8;
        run_cycle(sel inside {4,5}, sel inside {0,1}, sel inside {2,3}, 1'($urandom),
                  1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom),
                  8'($urandom), 8'($urandom), 8'($urandom));
    endtask

    initial begin
        void'($urandom(32'h5EED));
        cur_kind = K_QUIET; nxt_kind = K_QUIET; rv = '0;
        nxt_a = '0; nxt_b = '0; nxt_wd = '0;
        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10 ale", ale, 0); chk("R10 psen_n", psen_n, 1); chk("R10 rd_n", rd_n, 1);
        chk("R10 wr_n", wr_n, 1); chk("R10 p0_oe", p0_oe, 0);
        chk("R10 rdata_vld", rdata_vld, 0); chk("R10 slot_open", slot_open, 0);
        rst_n = 1'b1;
        // R10: first machine cycle after reset drives no strobe
        for (int i = 0; i < 20 && !slot_open; i++) begin
            @(negedge clk);
            chk("R10 quiet ale", ale, 0);
            chk("R10 quiet psen_n", psen_n, 1);
        end
        chk("R9 slot_open found", slot_open, 1);
        set_req(1, 0, 0, 0, 1, 0, 16'h1234, 16'h0, 8'h0, 8'h55, 8'h0);
        cur_kind = K_QUIET;
        // Directed cases: next-cycle request given as arguments.
        run_cycle(0, 1, 0, 1, 1, 0, 16'h0, 16'hBEEF, 8'h11, 8'h22, 8'h0);    // after fetch: read wide
        run_cycle(0, 0, 1, 0, 0, 0, 16'h0, 16'h0, 8'h3C, 8'hA5, 8'h96);      // write narrow
        run_cycle(1, 0, 0, 0, 1, 0, 16'hFFFF, 16'h0, 8'h0, 8'h0, 8'h0);      // R2 pc+1 wraps
        run_cycle(0, 1, 1, 0, 0, 0, 16'h0, 16'h0, 8'h77, 8'h44, 8'hEE);      // R9 read beats write
        run_cycle(0, 0, 0, 0, 0, 1, 16'h0, 16'h0, 8'h0, 8'h66, 8'h0);        // R8 idle suppressed
        run_cycle(0, 0, 0, 0, 1, 1, 16'h0, 16'h0, 8'h0, 8'h67, 8'h0);        // R8 ignored when external
        run_cycle(0, 0, 1, 1, 0, 1, 16'h0, 16'hC0DE, 8'h0, 8'h0, 8'h5A);     // R8 data still pulses
        run_cycle(1, 0, 0, 0, 0, 1, 16'h0800, 16'h0, 8'h0, 8'h0, 8'h0);      // R8 fetch still pulses
        run_cycle(0, 0, 0, 0, 0, 0, 16'h0, 16'h0, 8'h0, 8'h12, 8'h0);        // R11 idle
        run_cycle(0, 0, 0, 0, 0, 0, 16'h0, 16'h0, 8'h0, 8'h12, 8'h0);
        for (int i = 0; i < 150; i++) run_random();
        run_cycle(0, 0, 0, 0, 0, 0, 16'h0, 16'h0, 8'h0, 8'h0, 8'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule